// File: doc/BRIEF.md
# Inter-processor message target selector

This block decides which of N local interrupt units receive an inter-processor message. It takes the low and high command words of a message, the index of the sending unit, and per-unit identity: an 8-bit physical ID, an 8-bit logical ID and an enable flag. Each unit also has a destination-format register that lives inside the block. The result is a bitmask with one bit per unit. The block handles neither the vector payload nor the delivery itself.

For ordinary delivery modes the mask holds every unit that matches. The match can be physical, flat-logical or cluster-logical, and a shorthand code can override it. In lowest-priority mode the block picks exactly one unit in rotating order from the matching, enabled units. It keeps the index of its last choice, so successive messages spread across the units. The outputs are combinational from the inputs and the held state. Format writes and the rotation pointer take effect at the clock edge.

Top module: `ipi_target_sel`

## Requirements
- R1: After reset every format register reads 0xFFFFFFFF, which selects flat format. The rotation pointer is reset so that the first lowest-priority pick is the lowest-indexed qualifying unit, starting from unit 0.
- R2: With shorthand code 00 in cmd_lo[19:18] and cmd_lo[11]=0 (physical), a unit matches when the destination byte cmd_hi[31:24] is 0xFF or equals the unit's ID.
- R3: With cmd_lo[11]=1 (logical) and a format register whose top nibble is 0xF (flat), a unit matches when the AND of its logical ID and the destination byte is nonzero.
- R4: With cmd_lo[11]=1 and a format top nibble of 0x0 (cluster), a unit matches when the upper nibbles of its logical ID and the destination are equal and the AND of their lower nibbles is nonzero.
- R5: A unit whose format top nibble is neither 0xF nor 0x0 matches no logical destination.
- R6: The shorthand codes in cmd_lo[19:18] ignore the destination byte and mode. Code 01 selects only the sender. Code 10 selects every unit. Code 11 selects every unit except the sender.
- R7: A write to a unit's format register stores only bits 31:28. Bits 27:0 always read as ones.
- R8: When the delivery mode cmd_lo[10:8] is 001 (lowest priority), at most one target bit is set. The search begins at the unit after the last choice and wraps around. The target is the first unit that both matches and is enabled, and it becomes the new last choice at the clock edge.
- R9: In lowest-priority mode, if no unit both matches and is enabled, the mask is zero and the last choice is kept.
- R10: In any other delivery mode the enable flags do not affect the mask. With req_valid low the mask is zero and the last choice is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A message is presented this cycle |
| cmd_lo | input | 32 | Low command word (mode, destination mode, shorthand) |
| cmd_hi | input | 32 | High command word; destination byte in bits 31:24 |
| sender | input | SW | Index of the sending unit |
| unit_id | input | 8*N | Physical ID of each unit |
| unit_lid | input | 8*N | Logical ID of each unit |
| unit_en | input | N | Enable flag of each unit |
| fmt_we | input | N | Per-unit write strobe for the format register |
| fmt_wdata | input | 32 | Write data for the format register |
| tgt_mask | output | N | Selected target units |
| unit_fmt | output | 32*N | Read value of each unit's format register |

## Verification
The assertions assume that the sender index always names an existing unit and that req_valid and the command words are driven to known values whenever reset is released. The stimulus uses N=4, so every sender value is a real unit. It sets every input at the falling edge before it raises req_valid. The one-hot and enabled-only properties of the lowest-priority pick hold for any configuration of IDs. The stimulus therefore varies the enable masks and destinations freely, and keeps the format registers at 0xF, 0x0 or one deliberately invalid value.

// File: rtl/ipi_target_sel.sv
module ipi_target_sel #(
  parameter int N  = 4,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [31:0]     cmd_lo,
  input  logic [31:0]     cmd_hi,
  input  logic [SW-1:0]   sender,
  input  logic [N*8-1:0]  unit_id,
  input  logic [N*8-1:0]  unit_lid,
  input  logic [N-1:0]    unit_en,
  input  logic [N-1:0]    fmt_we,
  input  logic [31:0]     fmt_wdata,
  output logic [N-1:0]    tgt_mask,
  output logic [N*32-1:0] unit_fmt
);
  localparam logic [3:0] FMT_FLAT    = 4'hF;
  localparam logic [3:0] FMT_CLUSTER = 4'h0;
  localparam logic [2:0] MODE_LOWEST = 3'b001;

  logic [7:0]    dest;
  logic          logical;
  logic [1:0]    shand;
  logic          lowest;
  logic [3:0]    fmt_q [N];
  logic [SW-1:0] last_q;
  logic [N-1:0]  match;
  logic [N-1:0]  cand;
  logic          found;
  logic [SW-1:0] pick_idx;
  logic [N-1:0]  pick_oh;

  assign dest    = cmd_hi[31:24];
  assign logical = cmd_lo[11];
  assign shand   = cmd_lo[19:18];
  assign lowest  = (cmd_lo[10:8] == MODE_LOWEST);

  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic [7:0] id;
      logic [7:0] lid;
      logic       addr_hit;
      id  = unit_id[i*8 +: 8];
      lid = unit_lid[i*8 +: 8];
      if (!logical) begin
        addr_hit = (dest == 8'hFF) || (dest == id);
      end else begin
        case (fmt_q[i])
          FMT_FLAT:    addr_hit = |(lid & dest);
          FMT_CLUSTER: addr_hit = (lid[7:4] == dest[7:4]) && |(lid[3:0] & dest[3:0]);
          default:     addr_hit = 1'b0;
        endcase
      end
      case (shand)
        2'b00:   match[i] = addr_hit;
        2'b01:   match[i] = (i == int'(sender));
        2'b10:   match[i] = 1'b1;
        default: match[i] = (i != int'(sender));
      endcase
    end
  end

  assign cand = match & unit_en;

  always_comb begin
    found    = 1'b0;
    pick_idx = last_q;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(last_q) + k) % N;
      if (!found && cand[idx]) begin
        found    = 1'b1;
        pick_idx = SW'(idx);
      end
    end
  end

  assign pick_oh  = {{(N-1){1'b0}}, 1'b1} << pick_idx;
  assign tgt_mask = !req_valid ? '0 : (lowest ? (found ? pick_oh : '0) : match);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= SW'(N - 1);
    end else if (req_valid && lowest && found) begin
      last_q <= pick_idx;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_fmt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         fmt_q[g] <= FMT_FLAT;
      else if (fmt_we[g]) fmt_q[g] <= fmt_wdata[31:28];
    end
    assign unit_fmt[g*32 +: 32] = {fmt_q[g], 28'hFFF_FFFF};
  end
endmodule

// File: rtl/ipi_target_sel_chk.sv
module ipi_target_sel_chk #(
  parameter int N  = 4,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [31:0]     cmd_lo,
  input logic [SW-1:0]   sender,
  input logic [N-1:0]    unit_en,
  input logic [N-1:0]    tgt_mask,
  input logic [N*32-1:0] unit_fmt
);
  logic is_lowest;
  assign is_lowest = (cmd_lo[10:8] == 3'b001);

  a_r8_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_lowest) |-> $onehot0(tgt_mask));

  a_r8_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_lowest) |-> ((tgt_mask & ~unit_en) == '0));

  a_r6_excl_sender: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !is_lowest && cmd_lo[19:18] == 2'b11) |-> !tgt_mask[sender]);

  a_r6_self_only: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !is_lowest && cmd_lo[19:18] == 2'b01) |-> ($countones(tgt_mask) == 1 && tgt_mask[sender]));

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (tgt_mask == '0));

  for (genvar g = 0; g < N; g++) begin : g_fmt_chk
    a_r7_low_ones: assert property (@(posedge clk) disable iff (!rst_n)
      &unit_fmt[g*32 +: 28]);
  end
endmodule

bind ipi_target_sel ipi_target_sel_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cmd_lo(cmd_lo),
  .sender(sender), .unit_en(unit_en), .tgt_mask(tgt_mask), .unit_fmt(unit_fmt)
);

// File: tb/tb_ipi_target_sel.sv
module tb_ipi_target_sel;
  localparam int N  = 4;
  localparam int SW = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic [31:0]     cmd_lo = '0;
  logic [31:0]     cmd_hi = '0;
  logic [SW-1:0]   sender = '0;
  logic [N*8-1:0]  unit_id;
  logic [N*8-1:0]  unit_lid;
  logic [N-1:0]    unit_en = '1;
  logic [N-1:0]    fmt_we = '0;
  logic [31:0]     fmt_wdata = '0;
  logic [N-1:0]    tgt_mask;
  logic [N*32-1:0] unit_fmt;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  ipi_target_sel #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cmd_lo(cmd_lo),
    .cmd_hi(cmd_hi), .sender(sender), .unit_id(unit_id), .unit_lid(unit_lid),
    .unit_en(unit_en), .fmt_we(fmt_we), .fmt_wdata(fmt_wdata),
    .tgt_mask(tgt_mask), .unit_fmt(unit_fmt)
  );

  assign unit_id  = {8'h22, 8'h11, 8'h07, 8'h03};
  assign unit_lid = {8'h18, 8'h14, 8'h02, 8'h01};

  // {cmd_lo, cmd_hi, sender, expected mask}; flat format, all units enabled
  localparam int NV = 11;
  localparam logic [69:0] VEC [NV] = '{
    {32'h0000_0000, 32'h0700_0000, 2'd0, 4'b0010},  // R2 id hit
    {32'h0000_0000, 32'hFF00_0000, 2'd0, 4'b1111},  // R2 broadcast
    {32'h0000_0000, 32'h2200_0000, 2'd0, 4'b1000},  // R2
    {32'h0000_0000, 32'h5500_0000, 2'd0, 4'b0000},  // R2 miss
    {32'h0000_0800, 32'h0300_0000, 2'd0, 4'b0011},  // R3
    {32'h0000_0800, 32'h1000_0000, 2'd0, 4'b1100},  // R3
    {32'h0000_0800, 32'h2000_0000, 2'd0, 4'b0000},  // R3 miss
    {32'h0004_0000, 32'h0300_0000, 2'd2, 4'b0100},  // R6 self
    {32'h0008_0000, 32'h0000_0000, 2'd1, 4'b1111},  // R6 all
    {32'h000C_0000, 32'h0000_0000, 2'd1, 4'b1101},  // R6 all but sender
    {32'h0004_0800, 32'hFF00_0000, 2'd3, 4'b1000}   // R6 self overrides logical
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(logic rv, logic [31:0] lo, logic [31:0] hi, logic [SW-1:0] s, logic [N-1:0] en);
    @(negedge clk);
    req_valid = rv; cmd_lo = lo; cmd_hi = hi; sender = s; unit_en = en;
    #2;
  endtask

  task automatic wr_fmt(logic [N-1:0] we, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b0; fmt_we = we; fmt_wdata = d;
    @(negedge clk);
    fmt_we = '0;
    #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    for (int i = 0; i < N; i++) chk("R1 format reset", unit_fmt[i*32 +: 32], 32'hFFFF_FFFF);
    chk("R10 idle mask", {28'd0, tgt_mask}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      put(1'b1, VEC[v][69:38], VEC[v][37:6], VEC[v][5:4], 4'b1111);
      chk($sformatf("R2/R3/R6 vector %0d", v), {28'd0, tgt_mask}, {28'd0, VEC[v][3:0]});
    end

    put(1'b1, 32'h0, 32'hFF00_0000, 2'd0, 4'b0000);
    chk("R10 enable ignored", {28'd0, tgt_mask}, 32'hF);
    put(1'b0, 32'h0, 32'hFF00_0000, 2'd0, 4'b1111);
    chk("R10 req_valid low", {28'd0, tgt_mask}, 32'h0);

    put(1'b1, 32'h0008_0100, 32'h0, 2'd0, 4'b1111);
    chk("R1 first lowest pick", {28'd0, tgt_mask}, 32'h1);
    put(1'b1, 32'h0008_0100, 32'h0, 2'd0, 4'b1111);
    chk("R8 rotate", {28'd0, tgt_mask}, 32'h2);
    put(1'b1, 32'h0008_0100, 32'h0, 2'd0, 4'b1111);
    chk("R8 rotate", {28'd0, tgt_mask}, 32'h4);
    put(1'b1, 32'h0008_0100, 32'h0, 2'd0, 4'b1111);
    chk("R8 rotate", {28'd0, tgt_mask}, 32'h8);
    put(1'b1, 32'h0008_0100, 32'h0, 2'd0, 4'b1111);
    chk("R8 wrap", {28'd0, tgt_mask}, 32'h1);
    put(1'b1, 32'h0008_0100, 32'h0, 2'd0, 4'b1010);
    chk("R8 skip disabled", {28'd0, tgt_mask}, 32'h2);
    put(1'b1, 32'h0008_0100, 32'h0, 2'd0, 4'b1010);
    chk("R8 skip disabled", {28'd0, tgt_mask}, 32'h8);
    put(1'b1, 32'h0008_0100, 32'h0, 2'd0, 4'b1010);
    chk("R8 wrap disabled", {28'd0, tgt_mask}, 32'h2);
    put(1'b1, 32'h0008_0100, 32'h0, 2'd0, 4'b0000);
    chk("R9 none qualifies", {28'd0, tgt_mask}, 32'h0);
    put(1'b1, 32'h0008_0100, 32'h0, 2'd0, 4'b1111);
    chk("R9 pointer kept", {28'd0, tgt_mask}, 32'h4);
    put(1'b1, 32'h0000_0900, 32'h0300_0000, 2'd0, 4'b1111);
    chk("R8 logical subset", {28'd0, tgt_mask}, 32'h1);
    put(1'b1, 32'h0000_0900, 32'h0300_0000, 2'd0, 4'b1111);
    chk("R8 logical subset", {28'd0, tgt_mask}, 32'h2);
    put(1'b0, 32'h0008_0100, 32'h0, 2'd0, 4'b1111);
    put(1'b0, 32'h0008_0100, 32'h0, 2'd0, 4'b1111);
    put(1'b1, 32'h0008_0100, 32'h0, 2'd0, 4'b1111);
    chk("R10 idle keeps pointer", {28'd0, tgt_mask}, 32'h4);

    wr_fmt(4'b1111, 32'h0000_1234);
    for (int i = 0; i < N; i++) chk("R7 format write", unit_fmt[i*32 +: 32], 32'h0FFF_FFFF);
    put(1'b1, 32'h0000_0800, 32'h1400_0000, 2'd0, 4'b1111);
    chk("R4 cluster", {28'd0, tgt_mask}, 32'h4);
    put(1'b1, 32'h0000_0800, 32'h1C00_0000, 2'd0, 4'b1111);
    chk("R4 cluster", {28'd0, tgt_mask}, 32'hC);
    put(1'b1, 32'h0000_0800, 32'h0300_0000, 2'd0, 4'b1111);
    chk("R4 cluster", {28'd0, tgt_mask}, 32'h3);

    wr_fmt(4'b0100, 32'h5ABC_DEF0);
    chk("R7 partial write", unit_fmt[2*32 +: 32], 32'h5FFF_FFFF);
    put(1'b1, 32'h0000_0800, 32'h1C00_0000, 2'd0, 4'b1111);
    chk("R5 bad format", {28'd0, tgt_mask}, 32'h8);
    put(1'b1, 32'h0000_0000, 32'h1100_0000, 2'd0, 4'b1111);
    chk("R5 physical unaffected", {28'd0, tgt_mask}, 32'h4);

    put(1'b0, 32'h0, 32'h0, 2'd0, 4'b1111);
    finish_run();
  end
endmodule